// File: doc/BRIEF.md
# Banked GPIO Pad Control Registers

This block is the register front end for 56 general-purpose pads. The pads are split into three full banks of 16 and one half bank of 8. A plain 32-bit register bus, with an address, a write strobe, write data and combinational read data, reaches each bank's registers:

- output value
- sampled input
- direction
- two function-select planes
- an inverted open-drain control
- pull select
- pull enable

From these registers the block drives, for every pad:

- an output level and an output enable
- an open-drain flag
- a 2-bit function code that chooses GPIO or one of three alternate peripherals
- pull-up and pull-down requests

Pad inputs pass through a two-stage synchronizer before software sees them.

Each bank occupies a window of 0x30 bytes starting at bank index times 0x30. Pad `p` lives in bank `p / 16` at bit `p % 16`. The half bank (bank 3) keeps its output, input, direction and first select plane at the usual offsets in its own window at 0x90. Its open-drain, pull-select and pull-enable words sit in spare slots of bank 0 at 0x24, 0x28 and 0x2C. Its second select plane sits in a spare slot of bank 1 at 0x54.

Top module: `padctl_banks`

## Requirements
- R1: While reset is held and right after it, every writable register reads zero. Every pad then has output enable 0, function code 0, no pull, output 0 and open-drain flag 1.
- R2: A word at byte address `b*0x30 + off`, for bank b in 0..2, controls pads 16b..16b+15, with bit i mapped to pad 16b+i. The offsets are output 0x00, input 0x04, direction 0x08, select plane 0 0x0C, select plane 1 0x10, open-drain control 0x14, pull select 0x1C and pull enable 0x20. A write changes only the addressed bank's pads.
- R3: For bank 3 (pads 48..55), open-drain control is at 0x24, pull select at 0x28, pull enable at 0x2C and select plane 1 at 0x54. Output, input, direction and select plane 0 are at 0x90, 0x94, 0x98 and 0x9C. Bits 15..8 of every bank-3 word read 0, and the unused slots 0xA0..0xB0 of bank 3's own window are unmapped.
- R4: `pad_func[2p+1:2p]` equals {select plane 1 bit, select plane 0 bit} of pad p. Code 0 is GPIO and codes 1..3 are the alternates.
- R5: A direction bit of 1 makes the pad an output. With direction 0, `pad_oe` of that pad is 0.
- R6: An open-drain control bit of 1 means push-pull: `pad_od`=0 and `pad_oe`=direction. A bit of 0 means open drain: `pad_od`=1 and `pad_oe`=direction AND NOT output. `pad_out` always equals the output bit, so an open-drain pad never drives high.
- R7: With pull enable 1, pull select 1 raises `pad_pull_up` and pull select 0 raises `pad_pull_dn`. With pull enable 0, both are 0.
- R8: The input word returns each pad's level two clock edges after it was sampled. Writes to the input word have no effect.
- R9: Reads of unmapped or non-word-aligned addresses (address bits 1:0 not zero) return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register word |
| bus_we | input | 1 | Write strobe, captured at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pad_in | input | 56 | Pad input levels |
| pad_out | output | 56 | Pad output level |
| pad_oe | output | 56 | Pad output enable |
| pad_od | output | 56 | 1 when the pad is in open-drain mode |
| pad_func | output | 112 | 2-bit function code per pad |
| pad_pull_up | output | 56 | Pull-up request |
| pad_pull_dn | output | 56 | Pull-down request |

## Verification
A register write lands at the rising edge where `bus_we` is high. Every pad control output follows combinationally from the registers, so it is due one edge after the write. Read data is combinational on the address and is due within the same cycle. A pad input change becomes readable only after the second rising edge. The bench therefore drives on the falling edge and samples one nanosecond later, both for the cycle after a write and for the two cycles after a pad change, so that it can observe both the not-yet and the now value of the input word.

// File: rtl/padctl_pkg.sv
package padctl_pkg;

   typedef enum logic [3:0] {
      RK_OUT, RK_IN, RK_DIR, RK_FSEL0, RK_FSEL1,
      RK_ODN, RK_PSEL, RK_PEN, RK_NONE
   } reg_kind_e;

   // per-bank window and in-window word offsets
   localparam int unsigned BANK_STRIDE = 'h30;
   localparam int unsigned OFF_OUT     = 'h00;
   localparam int unsigned OFF_IN      = 'h04;
   localparam int unsigned OFF_DIR     = 'h08;
   localparam int unsigned OFF_FSEL0   = 'h0C;
   localparam int unsigned OFF_FSEL1   = 'h10;
   localparam int unsigned OFF_ODN     = 'h14;
   localparam int unsigned OFF_PSEL    = 'h1C;
   localparam int unsigned OFF_PEN     = 'h20;

   // relocated half-bank words, in spare slots of banks 0 and 1
   localparam int unsigned HB_ODN_ADDR   = 'h24;
   localparam int unsigned HB_PSEL_ADDR  = 'h28;
   localparam int unsigned HB_PEN_ADDR   = 'h2C;
   localparam int unsigned HB_FSEL1_ADDR = BANK_STRIDE + 'h24;

endpackage

// File: rtl/padctl_sync.sv
module padctl_sync #(
   parameter int WIDTH  = 56,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("padctl_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/padctl_regfile.sv
module padctl_regfile
   import padctl_pkg::*;
#(
   parameter int PPB        = 16,
   parameter int FULL_BANKS = 3,
   parameter int HALF_PINS  = 8,
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int NPADS      = FULL_BANKS*PPB + HALF_PINS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NPADS-1:0]  in_sync,
   output logic [NPADS-1:0]  out_q,
   output logic [NPADS-1:0]  dir_q,
   output logic [NPADS-1:0]  fsel0_q,
   output logic [NPADS-1:0]  fsel1_q,
   output logic [NPADS-1:0]  odn_q,
   output logic [NPADS-1:0]  psel_q,
   output logic [NPADS-1:0]  pen_q
);
   localparam int NBANKS = FULL_BANKS + 1;
   localparam int BANK_W = $clog2(NBANKS);

   reg_kind_e         kind;
   logic [BANK_W-1:0] bank;

   // address decode: relocated half-bank slots first, then regular windows
   always_comb begin
      int unsigned a, bk, off;
      a    = int'(bus_addr);
      bk   = a / BANK_STRIDE;
      off  = a % BANK_STRIDE;
      kind = RK_NONE;
      bank = '0;
      if (bus_addr[1:0] != 2'b00) begin
         kind = RK_NONE;
      end else if (a == HB_ODN_ADDR) begin
         kind = RK_ODN;   bank = BANK_W'(FULL_BANKS);
      end else if (a == HB_PSEL_ADDR) begin
         kind = RK_PSEL;  bank = BANK_W'(FULL_BANKS);
      end else if (a == HB_PEN_ADDR) begin
         kind = RK_PEN;   bank = BANK_W'(FULL_BANKS);
      end else if (a == HB_FSEL1_ADDR) begin
         kind = RK_FSEL1; bank = BANK_W'(FULL_BANKS);
      end else if (bk < NBANKS) begin
         bank = BANK_W'(bk);
         if      (off == OFF_OUT)   kind = RK_OUT;
         else if (off == OFF_IN)    kind = RK_IN;
         else if (off == OFF_DIR)   kind = RK_DIR;
         else if (off == OFF_FSEL0) kind = RK_FSEL0;
         else if (bk != FULL_BANKS) begin
            if      (off == OFF_FSEL1) kind = RK_FSEL1;
            else if (off == OFF_ODN)   kind = RK_ODN;
            else if (off == OFF_PSEL)  kind = RK_PSEL;
            else if (off == OFF_PEN)   kind = RK_PEN;
         end
      end
   end

   logic [DATA_W-1:0] rd_b [NBANKS];

   for (genvar b = 0; b < NBANKS; b++) begin : g_bank
      localparam int W  = (b == FULL_BANKS) ? HALF_PINS : PPB;
      localparam int LO = b * PPB;

      logic [W-1:0] out_r, dir_r, f0_r, f1_r, odn_r, ps_r, pe_r;
      logic         hit;
      logic [DATA_W-1:0] rd_w;

      assign hit = bus_we && (bank == BANK_W'(b));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_r <= '0; dir_r <= '0; f0_r <= '0; f1_r <= '0;
            odn_r <= '0; ps_r  <= '0; pe_r <= '0;
         end else if (hit) begin
            case (kind)
               RK_OUT:   out_r <= bus_wdata[W-1:0];
               RK_DIR:   dir_r <= bus_wdata[W-1:0];
               RK_FSEL0: f0_r  <= bus_wdata[W-1:0];
               RK_FSEL1: f1_r  <= bus_wdata[W-1:0];
               RK_ODN:   odn_r <= bus_wdata[W-1:0];
               RK_PSEL:  ps_r  <= bus_wdata[W-1:0];
               RK_PEN:   pe_r  <= bus_wdata[W-1:0];
               default:  ;
            endcase
         end
      end

      always_comb begin
         rd_w = '0;
         case (kind)
            RK_OUT:   rd_w[W-1:0] = out_r;
            RK_IN:    rd_w[W-1:0] = in_sync[LO +: W];
            RK_DIR:   rd_w[W-1:0] = dir_r;
            RK_FSEL0: rd_w[W-1:0] = f0_r;
            RK_FSEL1: rd_w[W-1:0] = f1_r;
            RK_ODN:   rd_w[W-1:0] = odn_r;
            RK_PSEL:  rd_w[W-1:0] = ps_r;
            RK_PEN:   rd_w[W-1:0] = pe_r;
            default:  rd_w = '0;
         endcase
      end

      assign rd_b[b]            = rd_w;
      assign out_q[LO +: W]     = out_r;
      assign dir_q[LO +: W]     = dir_r;
      assign fsel0_q[LO +: W]   = f0_r;
      assign fsel1_q[LO +: W]   = f1_r;
      assign odn_q[LO +: W]     = odn_r;
      assign psel_q[LO +: W]    = ps_r;
      assign pen_q[LO +: W]     = pe_r;
   end

   if (DATA_W > PPB) begin : g_hi
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^bus_wdata[DATA_W-1:PPB];
   end

   assign bus_rdata = (kind == RK_NONE) ? '0 : rd_b[bank];
endmodule

// File: rtl/padctl_drive.sv
module padctl_drive #(
   parameter int NPADS = 56
) (
   input  logic [NPADS-1:0]   out_q,
   input  logic [NPADS-1:0]   dir_q,
   input  logic [NPADS-1:0]   fsel0_q,
   input  logic [NPADS-1:0]   fsel1_q,
   input  logic [NPADS-1:0]   odn_q,
   input  logic [NPADS-1:0]   psel_q,
   input  logic [NPADS-1:0]   pen_q,
   output logic [NPADS-1:0]   pad_out,
   output logic [NPADS-1:0]   pad_oe,
   output logic [NPADS-1:0]   pad_od,
   output logic [2*NPADS-1:0] pad_func,
   output logic [NPADS-1:0]   pad_pull_up,
   output logic [NPADS-1:0]   pad_pull_dn
);
   for (genvar p = 0; p < NPADS; p++) begin : g_pad
      // open-drain control bit set = push-pull; cleared = release on high
      assign pad_out[p]         = out_q[p];
      assign pad_od[p]          = ~odn_q[p];
      assign pad_oe[p]          = dir_q[p] & (odn_q[p] | ~out_q[p]);
      assign pad_func[2*p +: 2] = {fsel1_q[p], fsel0_q[p]};
      assign pad_pull_up[p]     = pen_q[p] &  psel_q[p];
      assign pad_pull_dn[p]     = pen_q[p] & ~psel_q[p];
   end
endmodule

// File: rtl/padctl_banks.sv
module padctl_banks #(
   parameter int PPB        = 16,
   parameter int FULL_BANKS = 3,
   parameter int HALF_PINS  = 8,
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic [ADDR_W-1:0]                         bus_addr,
   input  logic                                      bus_we,
   input  logic [DATA_W-1:0]                         bus_wdata,
   output logic [DATA_W-1:0]                         bus_rdata,
   input  logic [FULL_BANKS*PPB+HALF_PINS-1:0]       pad_in,
   output logic [FULL_BANKS*PPB+HALF_PINS-1:0]       pad_out,
   output logic [FULL_BANKS*PPB+HALF_PINS-1:0]       pad_oe,
   output logic [FULL_BANKS*PPB+HALF_PINS-1:0]       pad_od,
   output logic [2*(FULL_BANKS*PPB+HALF_PINS)-1:0]   pad_func,
   output logic [FULL_BANKS*PPB+HALF_PINS-1:0]       pad_pull_up,
   output logic [FULL_BANKS*PPB+HALF_PINS-1:0]       pad_pull_dn
);
   localparam int NPADS = FULL_BANKS*PPB + HALF_PINS;

   // elaboration-time parameter checks
   if (PPB > DATA_W) begin : g_bad_ppb
      $error("padctl_banks: PPB exceeds DATA_W");
   end
   if (HALF_PINS < 1 || HALF_PINS >= PPB) begin : g_bad_half
      $error("padctl_banks: HALF_PINS must be 1..PPB-1");
   end
   if (FULL_BANKS < 2) begin : g_bad_banks
      $error("padctl_banks: relocated slots need banks 0 and 1");
   end
   if ((FULL_BANKS+1)*int'(padctl_pkg::BANK_STRIDE) > (1 << ADDR_W)) begin : g_bad_addr
      $error("padctl_banks: ADDR_W too narrow for the bank windows");
   end

   logic [NPADS-1:0] in_sync, out_q, dir_q, fsel0_q, fsel1_q, odn_q, psel_q, pen_q;

   padctl_sync #(.WIDTH(NPADS), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(in_sync)
   );

   padctl_regfile #(
      .PPB(PPB), .FULL_BANKS(FULL_BANKS), .HALF_PINS(HALF_PINS),
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NPADS(NPADS)
   ) regs_i (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .in_sync(in_sync),
      .out_q(out_q), .dir_q(dir_q), .fsel0_q(fsel0_q), .fsel1_q(fsel1_q),
      .odn_q(odn_q), .psel_q(psel_q), .pen_q(pen_q)
   );

   padctl_drive #(.NPADS(NPADS)) drive_i (
      .out_q(out_q), .dir_q(dir_q), .fsel0_q(fsel0_q), .fsel1_q(fsel1_q),
      .odn_q(odn_q), .psel_q(psel_q), .pen_q(pen_q),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od),
      .pad_func(pad_func), .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn)
   );
endmodule

// File: rtl/padctl_banks_chk.sv
module padctl_banks_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int NPADS  = 56
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [NPADS-1:0]  pad_in,
   input logic [NPADS-1:0]  pad_out,
   input logic [NPADS-1:0]  pad_oe,
   input logic [NPADS-1:0]  pad_od,
   input logic [2*NPADS-1:0] pad_func,
   input logic [NPADS-1:0]  pad_pull_up,
   input logic [NPADS-1:0]  pad_pull_dn
);
   localparam logic [ADDR_W-1:0] A_IN0    = ADDR_W'('h04);
   localparam logic [ADDR_W-1:0] A_DIR0   = ADDR_W'('h08);
   localparam logic [ADDR_W-1:0] A_FSEL00 = ADDR_W'('h0C);
   localparam logic [ADDR_W-1:0] A_PEN0   = ADDR_W'('h20);
   localparam logic [ADDR_W-1:0] A_HOLE3  = ADDR_W'('hA4);
   localparam logic [ADDR_W-1:0] A_HOLE0  = ADDR_W'('h18);

   // cycles since reset release, saturating
   logic [1:0] cyc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cyc <= '0;
      else if (cyc != 3) cyc <= cyc + 2'd1;
   end

   // R1: reset forces idle pads
   always @(negedge clk) begin
      if (!rst_n) begin
         a_r1_reset_idle: assert (pad_oe == '0 && pad_func == '0 &&
                                  pad_pull_up == '0 && pad_pull_dn == '0 &&
                                  pad_od == '1);
      end
   end

   a_r4_fsel0_lsb: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_we && bus_addr == A_FSEL00) |-> pad_func[0] == $past(bus_wdata[0]));

   a_r5_dir_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_we && bus_addr == A_DIR0 && bus_wdata[15:0] == '0) |-> pad_oe[15:0] == '0);

   a_r6_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_od & pad_out & pad_oe) == '0);

   a_r7_pen_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_we && bus_addr == A_PEN0 && bus_wdata[15:0] == '0) |->
      (pad_pull_up[15:0] == '0 && pad_pull_dn[15:0] == '0));

   a_r8_input_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 3 && bus_addr == A_IN0) |-> bus_rdata[15:0] == $past(pad_in[15:0], 2));

   a_r3_spare_slot_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_we && bus_addr == A_HOLE3) |-> $stable(pad_od));

   a_r9_hole_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_we && bus_addr == A_HOLE0) |->
      ($stable(pad_oe) && $stable(pad_out) && $stable(pad_func)));
endmodule

bind padctl_banks padctl_banks_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NPADS(FULL_BANKS*PPB+HALF_PINS)
) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
   .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od), .pad_func(pad_func),
   .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn)
);

// File: tb/padctl_banks_tb_top.sv
`timescale 1ns/1ps
module padctl_banks_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [7:0]   bus_addr = '0;
   logic         bus_we = 1'b0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic [55:0]  pad_in = '0;
   logic [55:0]  pad_out, pad_oe, pad_od, pad_pull_up, pad_pull_dn;
   logic [111:0] pad_func;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   padctl_banks dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od), .pad_func(pad_func),
      .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn)
   );

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
      #1;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      for (int a = 0; a < 'hB4; a += 4) begin
         bus_rd(8'(a), d);
         chk("R1 register zero after reset", d, 0);
      end
      chk("R1 pad_oe", pad_oe, 0);
      chk("R1 pad_func", pad_func, 0);
      chk("R1 pulls", {pad_pull_up, pad_pull_dn}, 0);
      chk("R1 pad_out", pad_out, 0);
      chk("R1 pad_od", pad_od, {56{1'b1}});
   endtask

   task automatic t_bank_map;
      logic [31:0] d;
      bus_wr(8'h38, 32'h0000_A5A5);          // bank 1 direction
      bus_rd(8'h38, d);
      chk("R2 bank1 dir readback", d, 32'hA5A5);
      chk("R2 bank1 pads enabled", pad_oe[31:16], 16'hA5A5);
      chk("R2 other banks untouched", {pad_oe[55:32], pad_oe[15:0]}, 0);
      bus_wr(8'h60, 32'h0000_0020);          // bank 2 output bit 5 = pad 37
      chk("R2 pad 37 output", pad_out, 56'h1 << 37);
   endtask

   task automatic t_half_bank;
      logic [31:0] d;
      bus_wr(8'h24, 32'h0000_FFFF);
      bus_rd(8'h24, d);
      chk("R3 half-bank od read width", d, 32'h00FF);
      chk("R3 half-bank push-pull", pad_od[55:48], 8'h00);
      chk("R3 full banks still open-drain", pad_od[47:0], {48{1'b1}});
      bus_wr(8'h54, 32'h0000_0081);
      chk("R3 half-bank select plane 1", pad_func[111:96], 16'h8002);
      bus_rd(8'h40, d);
      chk("R3 bank1 select plane 1 untouched", d, 0);
      bus_wr(8'h98, 32'h0000_FFFF);
      bus_rd(8'h98, d);
      chk("R3 half-bank dir read width", d, 32'h00FF);
      chk("R3 half-bank oe", pad_oe[55:48], 8'hFF);
      bus_wr(8'hA4, 32'h0000_0000);
      chk("R3 own-window od slot ignored", pad_od[55:48], 8'h00);
      bus_rd(8'hA4, d);
      chk("R3 own-window od slot reads zero", d, 0);
      bus_wr(8'h28, 32'h0000_000F);
      bus_wr(8'h2C, 32'h0000_0003);
      chk("R3 half-bank pull up", pad_pull_up[55:48], 8'h03);
      chk("R3 half-bank pull down", pad_pull_dn[55:48], 8'h00);
   endtask

   task automatic t_func;
      bus_wr(8'h0C, 32'h0000_0003);
      bus_wr(8'h10, 32'h0000_0006);
      chk("R4 function codes pads 0..3", pad_func[7:0], 8'h2D);
   endtask

   task automatic t_drive;
      bus_wr(8'h14, 32'h0000_0003);          // pads 0,1 push-pull
      bus_wr(8'h00, 32'h0000_0005);
      bus_wr(8'h08, 32'h0000_000D);
      chk("R6 output enables", pad_oe[3:0], 4'h9);
      chk("R6 open-drain flags", pad_od[3:0], 4'hC);
      chk("R6 output levels", pad_out[3:0], 4'h5);
      bus_wr(8'h08, 32'h0000_0000);
      chk("R5 direction cleared", pad_oe[15:0], 16'h0000);
   endtask

   task automatic t_pull;
      bus_wr(8'h1C, 32'h0000_0005);
      bus_wr(8'h20, 32'h0000_0003);
      chk("R7 pull up", pad_pull_up[2:0], 3'b001);
      chk("R7 pull down", pad_pull_dn[2:0], 3'b010);
      bus_wr(8'h20, 32'h0000_0000);
      chk("R7 pull disabled", {pad_pull_up[15:0], pad_pull_dn[15:0]}, 0);
   endtask

   task automatic t_input;
      logic [31:0] d;
      @(negedge clk);
      pad_in = {8'hFF, 32'h0, 16'h1234};
      bus_addr = 8'h04;
      @(negedge clk); #1;
      chk("R8 input not yet visible", bus_rdata, 0);
      @(negedge clk); #1;
      chk("R8 input after two edges", bus_rdata, 32'h1234);
      bus_rd(8'h94, d);
      chk("R8 half-bank input", d, 32'h00FF);
      bus_wr(8'h04, 32'h0000_FFFF);
      bus_rd(8'h04, d);
      chk("R8 input write ignored", d, 32'h1234);
   endtask

   task automatic t_unmapped;
      logic [31:0]  d;
      logic [55:0]  s_out, s_oe, s_od;
      logic [111:0] s_func;
      s_out = pad_out; s_oe = pad_oe; s_od = pad_od; s_func = pad_func;
      bus_wr(8'h18, 32'hFFFF_FFFF);
      bus_wr(8'hB0, 32'hFFFF_FFFF);
      bus_wr(8'h26, 32'hFFFF_FFFF);
      bus_rd(8'h18, d);
      chk("R9 hole 0x18 reads zero", d, 0);
      bus_rd(8'hB0, d);
      chk("R9 0xB0 reads zero", d, 0);
      bus_rd(8'h26, d);
      chk("R9 misaligned reads zero", d, 0);
      chk("R9 outputs unchanged", {s_out, s_oe, s_od}, {pad_out, pad_oe, pad_od});
      chk("R9 function unchanged", s_func, pad_func);
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_bank_map();
      t_half_bank();
      t_func();
      t_drive();
      t_pull();
      t_input();
      t_unmapped();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule